// File: doc/BRIEF.md
# Interrupt Controller with Flag Latching and Halt Release

This block collects one-cycle event pulses from up to fourteen peripheral sources and latches each into a sticky pending flag. Software reads and writes three 16-bit registers over a simple synchronous register bus: a per-source enable mask, the pending flags and a master enable. Pending flags are cleared by writing ones. The controller drives a level interrupt request to the processor core. The request is high whenever an enabled flag is pending, the master enable is set and the core's own interrupt mask input is low.

The request is a pure function of the stored state and the core mask, so it is re-evaluated on every cycle. A flag that arrived while its source or the master enable was off raises the request in the cycle after software turns either of them back on, with no new pulse needed. Software can also request a halt through a write-only location. The halt ends only in a cycle in which an interrupt is actually delivered to the core.

Top module: `irq_ctl`

## Requirements
- R1: After reset the enable, flag and master-enable registers read 0, `halted` is 0 and `irq_req` is 0.
- R2: A pulse on `src_pulse[i]` sets flag bit i, readable at offset 0x202. Flag bits that are already set stay set until software clears them. Flag bits 15:14 always read 0.
- R3: A write to offset 0x202 clears every flag bit written as 1 and leaves the flag bits written as 0 unchanged.
- R4: If a source pulse and a clearing write hit the same flag bit in the same cycle, the bit ends set.
- R5: `irq_req` is 1 exactly when (enable AND flags) is nonzero, master-enable bit 0 is 1 and `core_irq_mask` is 0.
- R6: When a flag is already pending, a write to offset 0x200 that enables that flag's source raises `irq_req` in the next cycle, provided the master enable is set and the core mask is 0.
- R7: When an enabled flag is already pending, a write of 1 to bit 0 of offset 0x208 raises `irq_req` in the next cycle, provided the core mask is 0.
- R8: A write to offset 0x300 with bit 8 equal to 0 sets `halted`. A write there with bit 8 equal to 1 leaves `halted` unchanged.
- R9: In any cycle in which `irq_req` is 1, `halted` is 0 from the next cycle on. A delivered interrupt overrides a halt write made in the same cycle.
- R10: Reads are combinational from `bus_addr`. Offset 0x200 returns all 16 enable bits. Offset 0x208 returns only master-enable bit 0, with the other bits 0. Every other offset, including 0x300, reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 12 | Byte offset for reads and writes |
| bus_wr | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` |
| src_pulse | input | 14 | One-cycle event pulses, one per source |
| core_irq_mask | input | 1 | Core interrupt mask; 1 blocks delivery |
| irq_req | output | 1 | Level interrupt request to the core |
| halted | output | 1 | Core halt state; 1 while halted |

## Verification
The hardest case to reach from the ports is a flag that is already pending while its source, the master enable or the core mask blocks it. The request must then rise on the write that unmasks it alone, without any new pulse. The stimulus builds this up in steps. It latches flags while the master enable is 0, then writes the master enable. It clears a source's enable bit, pulses the source and re-enables it. It also holds the core mask high across a halt and a pulse, so the halt has to persist until the mask drops. A same-cycle pulse and clearing write on one bit, plus a long random mix of writes, pulses and mask changes, are compared against a behavioural model on every clock.

// File: rtl/irq_ctl.sv
module irq_ctl #(
  parameter int NSRC    = 14,
  parameter int DW      = 16,
  parameter int AW      = 12,
  parameter logic [AW-1:0] EN_OFS  = 12'h200,
  parameter logic [AW-1:0] FLG_OFS = 12'h202,
  parameter logic [AW-1:0] MEN_OFS = 12'h208,
  parameter logic [AW-1:0] HLT_OFS = 12'h300,
  parameter int HLT_BIT = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   bus_addr,
  input  logic            bus_wr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  input  logic [NSRC-1:0] src_pulse,
  input  logic            core_irq_mask,
  output logic            irq_req,
  output logic            halted
);

  logic [DW-1:0] en_q, flg_q, flg_nxt, src_ext, clr_mask;
  logic          men_q, halt_q;
  logic          wr_en, wr_flg, wr_men, wr_hlt;

  assign wr_en  = bus_wr && (bus_addr == EN_OFS);
  assign wr_flg = bus_wr && (bus_addr == FLG_OFS);
  assign wr_men = bus_wr && (bus_addr == MEN_OFS);
  assign wr_hlt = bus_wr && (bus_addr == HLT_OFS);

  always_comb begin
    src_ext = '0;
    src_ext[NSRC-1:0] = src_pulse;
  end

  assign clr_mask = wr_flg ? bus_wdata : '0;
  assign flg_nxt  = (flg_q & ~clr_mask) | src_ext;

  assign irq_req = !core_irq_mask && men_q && |(en_q & flg_q);
  assign halted  = halt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= '0;
      flg_q  <= '0;
      men_q  <= 1'b0;
      halt_q <= 1'b0;
    end else begin
      if (wr_en)  en_q  <= bus_wdata;
      if (wr_men) men_q <= bus_wdata[0];
      flg_q <= flg_nxt;
      if (irq_req)                             halt_q <= 1'b0;
      else if (wr_hlt && !bus_wdata[HLT_BIT])  halt_q <= 1'b1;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == EN_OFS)       bus_rdata = en_q;
    else if (bus_addr == FLG_OFS) bus_rdata = flg_q;
    else if (bus_addr == MEN_OFS) bus_rdata[0] = men_q;
  end

  a_r2_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_flg |=> ((flg_q & $past(flg_q)) == $past(flg_q)));

  a_r3_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
    wr_flg |=> ((flg_q & $past(bus_wdata & ~src_ext)) == '0));

  a_r4_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (src_pulse != '0) |=> ((flg_q & $past(src_ext)) == $past(src_ext)));

  a_r6_enable_refires: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && men_q && |(bus_wdata & flg_q) && !core_irq_mask) |=> (irq_req || core_irq_mask));

  a_r7_master_refires: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_men && bus_wdata[0] && |(en_q & flg_q) && !core_irq_mask) |=> (irq_req || core_irq_mask));

  a_r8_halt_enters: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hlt && !bus_wdata[HLT_BIT] && !irq_req) |=> halted);

  a_r9_delivery_wakes: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |=> !halted);

endmodule

// File: tb/test_irq_ctl.sv
module test_irq_ctl;
  logic        clk = 0, rst_n = 0;
  logic [11:0] bus_addr = '0;
  logic        bus_wr = 0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [13:0] src_pulse = '0;
  logic        core_irq_mask = 0;
  logic        irq_req, halted;

  irq_ctl i_irq_ctl (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_pulse(src_pulse),
    .core_irq_mask(core_irq_mask), .irq_req(irq_req), .halted(halted));

  always #2 clk = ~clk;

  int total = 0, bad = 0;
  bit finished = 0;
  int m_en = 0, m_flg = 0, m_men = 0, m_halt = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic int exp_irq();
    return (!core_irq_mask && m_men != 0 && (m_en & m_flg) != 0) ? 1 : 0;
  endfunction

  function automatic int exp_rd(input int a);
    if (a == 'h200) return m_en;
    if (a == 'h202) return m_flg;
    if (a == 'h208) return m_men;
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_en = 0; m_flg = 0; m_men = 0; m_halt = 0;
    end else begin
      int clr, dl;
      dl  = exp_irq();
      clr = (bus_wr && bus_addr == 'h202) ? int'(bus_wdata) : 0;
      if (dl != 0) m_halt = 0;
      else if (bus_wr && bus_addr == 'h300 && !bus_wdata[8]) m_halt = 1;
      m_flg = (m_flg & ~clr & 'hFFFF) | int'(src_pulse);
      if (bus_wr && bus_addr == 'h200) m_en = int'(bus_wdata);
      if (bus_wr && bus_addr == 'h208) m_men = int'(bus_wdata[0]);
    end
  end

  always @(negedge clk) begin
    #1;
    if (rst_n && !finished) begin
      check(int'(irq_req) == exp_irq(), "R5 irq level", int'(irq_req), exp_irq());
      check(int'(halted) == m_halt, "R8/R9 halt", int'(halted), m_halt);
      check(int'(bus_rdata) == exp_rd(int'(bus_addr)), "R10 read", int'(bus_rdata), exp_rd(int'(bus_addr)));
    end
  end

  task automatic step(input bit w, input int a, input int d, input int s);
    @(negedge clk);
    bus_wr = w; bus_addr = 12'(a); bus_wdata = 16'(d); src_pulse = 14'(s);
    @(posedge clk); #1;
    bus_wr = 0; src_pulse = '0;
  endtask

  task automatic peek(input int a, output int rd);
    @(negedge clk);
    bus_addr = 12'(a);
    #1 rd = int'(bus_rdata);
  endtask

  task automatic settle();
    @(negedge clk); #1;
  endtask

  initial begin
    #400000;
    bad++; total++;
    $display("FAIL watchdog act=1 exp=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int rd;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    peek('h200, rd); check(rd == 0, "R1 enable reset", rd, 0);
    peek('h202, rd); check(rd == 0, "R1 flags reset", rd, 0);
    peek('h208, rd); check(rd == 0, "R1 master reset", rd, 0);
    check(!irq_req && !halted, "R1 outputs reset", int'({irq_req, halted}), 0);

    step(1, 'h200, 'hFFFF, 0);
    peek('h200, rd); check(rd == 'hFFFF, "R10 enable full width", rd, 'hFFFF);
    step(1, 'h200, 'h0005, 0);
    // R2 latching while master off
    step(0, 'h202, 0, 'h0001);
    step(0, 'h202, 0, 'h0002);
    peek('h202, rd); check(rd == 'h3, "R2 sticky flags", rd, 'h3);
    check(!irq_req, "R5 master off", int'(irq_req), 0);
    // R7 master enable re-evaluation
    step(1, 'h208, 'h0001, 0);
    settle(); check(irq_req, "R7 pending fires on master write", int'(irq_req), 1);
    core_irq_mask = 1;
    settle(); check(!irq_req, "R5 core mask blocks", int'(irq_req), 0);
    core_irq_mask = 0;
    // R3 write-one-to-clear
    step(1, 'h202, 'h0001, 0);
    peek('h202, rd); check(rd == 'h2, "R3 clear bit0 only", rd, 'h2);
    check(!irq_req, "R3 irq drops after clear", int'(irq_req), 0);
    // R6 enable re-evaluation
    step(1, 'h200, 'h0007, 0);
    settle(); check(irq_req, "R6 pending fires on enable write", int'(irq_req), 1);
    step(1, 'h200, 'h0005, 0);
    // R4 set wins
    step(1, 'h202, 'h0004, 'h0004);
    peek('h202, rd); check(rd == 'h6, "R4 set beats clear", rd, 'h6);
    step(1, 'h202, 'hFFFF, 0);
    peek('h202, rd); check(rd == 0, "R3 clear all", rd, 0);
    // R8 halt control
    step(1, 'h300, 'h0100, 0);
    settle(); check(!halted, "R8 bit8 set ignored", int'(halted), 0);
    step(1, 'h300, 'h0000, 0);
    settle(); check(halted, "R8 halt entered", int'(halted), 1);
    core_irq_mask = 1;
    step(0, 'h202, 0, 'h0001);
    repeat (3) settle();
    check(halted, "R9 masked pulse keeps halt", int'(halted), 1);
    core_irq_mask = 0;
    settle(); settle();
    check(!halted, "R9 delivery releases halt", int'(halted), 0);
    // R9 halt write during delivery
    step(1, 'h300, 'h0000, 0);
    settle(); check(!halted, "R9 delivery beats halt write", int'(halted), 0);
    step(1, 'h202, 'hFFFF, 0);
    // R10 read masking
    step(1, 'h208, 'h00FE, 0);
    peek('h208, rd); check(rd == 0, "R10 master bit0 only", rd, 0);
    step(1, 'h208, 'h00FF, 0);
    peek('h208, rd); check(rd == 1, "R10 master reads 1", rd, 1);
    peek('h204, rd); check(rd == 0, "R10 unmapped", rd, 0);
    peek('h300, rd); check(rd == 0, "R10 halt slot reads 0", rd, 0);
    // random mix, compared every clock
    for (int i = 0; i < 2000; i++) begin
      int sel, a, d, s;
      sel = int'($urandom_range(0, 5));
      a = (sel == 0) ? 'h200 : (sel == 1) ? 'h202 : (sel == 2) ? 'h208 :
          (sel == 3) ? 'h300 : (sel == 4) ? 'h204 : 'h202;
      d = int'($urandom_range(0, 'hFFFF));
      s = ($urandom_range(0, 3) == 0) ? int'($urandom_range(0, 'h3FFF)) : 0;
      if ($urandom_range(0, 7) == 0) core_irq_mask = ~core_irq_mask;
      step($urandom_range(0, 2) == 0, a, d, s);
    end
    settle();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule